// File: doc/BRIEF.md
# Interleaved Burst Instruction Fetch Controller

This controller serves a processor's instruction fetches from read-only code memory that is split into four interleaved banks. The processor gives one word address together with a request strobe. The controller stores that address in its own counter and steps it forward each clock. Consecutive words therefore fall into consecutive banks. A bank is started every clock, and each bank has several clocks to complete its access before it is selected again. The access time of a single bank is hidden in this way. After the initial latency, the processor receives one 32-bit instruction per clock.

A burst always returns at least four words. After the fourth word it continues for as long as the processor holds its burst-continue input high. The first clock in which that input is low ends the burst. A new request at any point abandons the running burst, discards words that are still in flight, and starts a fresh burst at the new address. The bank arrays are external and have a fixed access time of `ACC_CYC` clocks, with 1 ≤ `ACC_CYC` ≤ 3. Each bank latches the in-bank address, which is `code_addr[15:2]`, on a clock edge at which its select line is high. It drives the data when its output-enable line is high, exactly `ACC_CYC` clocks later.

Top module: `ifb_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `instr_valid`, every `bank_sel` bit and every `bank_oe` bit are 0. A reset during a burst ends that burst.
- R2: The first word of a burst is shown on `instr` with `instr_valid` high in the cycle that follows the (`ACC_CYC`+1)th rising edge after the edge that sampled `req_valid`. With `ACC_CYC` at most 3, this is no later than four clocks after the request.
- R3: After the first word, `instr_valid` stays high without gaps, and word n of a burst that starts at address S carries the contents of address S+n.
- R4: A burst delivers at least four words even if `burst_en` is low from the request onward.
- R5: For issue cycles after the fourth word, the burst goes on while `burst_en` is high and stops in the first cycle in which it is low. A later high level on `burst_en` issues nothing until a new request arrives.
- R6: Bank number = word address bits [1:0]. In each issue cycle exactly one `bank_sel` bit is high, the one for bank `code_addr[1:0]`, and `code_addr` is the word being fetched. Successive issue cycles select the banks in ascending order modulo 4. `bank_sel` is all zero when nothing is issued, including the cycle in which `req_valid` is high.
- R7: A bank's `bank_oe` bit is high alone, exactly `ACC_CYC` cycles after the cycle in which that bank was selected, and the data is taken from that bank only.
- R8: A `req_valid` during a burst makes `instr_valid` low in the next cycle. No word of the old burst and no output enable for it appears afterwards.
- R9: The local address counter wraps from the highest word address to 0 and continues.
- R10: `instr_valid` is low during the initial latency and whenever no burst is delivering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New fetch address present (branch) |
| req_addr | input | 16 | Word address of the new fetch |
| burst_en | input | 1 | Keep the burst going past four words |
| code_addr | output | 16 | Locally generated word address of the access issued this cycle |
| bank_sel | output | 4 | Per-bank select; bank latches `code_addr[15:2]` |
| bank_oe | output | 4 | Per-bank output enable |
| bank_rdata | input | 128 | Bank read data, bank b in bits [32b+31:32b] |
| instr | output | 32 | Instruction word to the processor |
| instr_valid | output | 1 | `instr` holds a word this cycle |

## Verification
The hardest situation to reach is a new request that lands while earlier words are still inside the bank access pipeline. This is the case where stale data could appear among the new burst's words, for example in the very cycle in which the old burst's first word becomes visible. The bench starts a burst and, a chosen number of clocks later, issues a second request. One such point is exactly the cycle of the first visible word. It then checks every cycle until the new first word that no output enable and no valid word belongs to the old address. The external bank model returns an address-derived pattern, so a word from the wrong bank or from a stale address shows up as a data mismatch.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BANK_W    = 2;
    localparam int unsigned NUM_BANKS = 1 << BANK_W;
    localparam int unsigned IBANK_W   = ADDR_W - BANK_W;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        BS_IDLE,
        BS_RUN
    } bstate_e;

    // one issued access travelling toward the return stage
    typedef struct packed {
        logic  vld;
        bank_t bank;
    } slot_t;

    function automatic bank_t bank_of(waddr_t a);
        return a[BANK_W-1:0];
    endfunction

endpackage

// File: rtl/ifb_addr_gen.sv
module ifb_addr_gen
    import ifb_pkg::*;
#(
    parameter int unsigned MIN_BURST = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  waddr_t req_addr,
    input  logic   burst_en,
    output slot_t  issue,
    output waddr_t issue_addr
);

    localparam int unsigned CNT_W = $clog2(MIN_BURST + 1);

    bstate_e    state;
    waddr_t     cur_addr;
    logic [CNT_W-1:0] cnt;
    logic       more;
    logic       issue_go;

    // issue while under the minimum, or while the processor asks for more
    assign more     = (cnt < CNT_W'(MIN_BURST)) || burst_en;
    assign issue_go = (state == BS_RUN) && more && !req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BS_IDLE;
            cur_addr <= '0;
            cnt      <= '0;
        end else if (req_valid) begin
            state    <= BS_RUN;
            cur_addr <= req_addr;
            cnt      <= '0;
        end else if (state == BS_RUN) begin
            if (more) begin
                cur_addr <= cur_addr + ADDR_W'(1);
                if (cnt < CNT_W'(MIN_BURST)) begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                state <= BS_IDLE;
            end
        end
    end

    assign issue.vld  = issue_go;
    assign issue.bank = bank_of(cur_addr);
    assign issue_addr = cur_addr;

    // R3 / R9: back-to-back issues use consecutive addresses, wrapping modulo 2^ADDR_W
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_go && $past(issue_go)) |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

endmodule

// File: rtl/ifb_bank_decode.sv
module ifb_bank_decode
    import ifb_pkg::*;
(
    input  slot_t                issue,
    output logic [NUM_BANKS-1:0] bank_sel
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign bank_sel[b] = issue.vld && (issue.bank == bank_t'(b));
    end

endmodule

// File: rtl/ifb_return_pipe.sv
module ifb_return_pipe
    import ifb_pkg::*;
#(
    parameter int unsigned ACC_CYC = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  slot_t                       issue,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
    output logic [NUM_BANKS-1:0]        bank_oe,
    output word_t                       instr,
    output logic                        instr_valid
);

    slot_t pipe [ACC_CYC];
    slot_t tail;
    word_t rsel;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int j = 0; j < int'(ACC_CYC); j++) begin
                pipe[j] <= '0;
            end
        end else begin
            pipe[0] <= issue;
            for (int j = 1; j < int'(ACC_CYC); j++) begin
                pipe[j] <= pipe[j-1];
            end
        end
    end

    assign tail = pipe[ACC_CYC-1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_oe
        assign bank_oe[b] = tail.vld && (tail.bank == bank_t'(b));
    end

    assign rsel = bank_rdata[int'(tail.bank)*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_valid <= 1'b0;
            instr       <= '0;
        end else begin
            instr_valid <= tail.vld && !flush;
            if (tail.vld) begin
                instr <= rsel;
            end
        end
    end

    // R7: an enabled bank is always followed by a delivered word unless cancelled
    assert_oe_delivers_R7: assert property (@(posedge clk) disable iff (rst)
        ((|bank_oe) && !flush) |=> instr_valid);

endmodule

// File: rtl/ifb_ctrl.sv
module ifb_ctrl
    import ifb_pkg::*;
#(
    parameter int unsigned ACC_CYC   = 2,
    parameter int unsigned MIN_BURST = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        burst_en,
    output logic [ADDR_W-1:0]           code_addr,
    output logic [NUM_BANKS-1:0]        bank_sel,
    output logic [NUM_BANKS-1:0]        bank_oe,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
    output logic [DATA_W-1:0]           instr,
    output logic                        instr_valid
);

    slot_t issue;

    ifb_addr_gen #(.MIN_BURST(MIN_BURST)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .burst_en   (burst_en),
        .issue      (issue),
        .issue_addr (code_addr)
    );

    ifb_bank_decode u_dec (
        .issue    (issue),
        .bank_sel (bank_sel)
    );

    ifb_return_pipe #(.ACC_CYC(ACC_CYC)) u_ret (
        .clk         (clk),
        .rst         (rst),
        .flush       (req_valid),
        .issue       (issue),
        .bank_rdata  (bank_rdata),
        .bank_oe     (bank_oe),
        .instr       (instr),
        .instr_valid (instr_valid)
    );

    // R8: a new request removes any pending word from the next cycle
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !instr_valid);

    // R6: the selected bank agrees with the low bits of the local address
    assert_bank_match_R6: assert property (@(posedge clk) disable iff (rst)
        (|bank_sel) |-> bank_sel[code_addr[BANK_W-1:0]]);

    // R6: no access is issued in a request cycle
    assert_req_no_sel_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (bank_sel == '0));

endmodule

// File: tb/test_ifb_ctrl.sv
`timescale 1ns/1ps
module test_ifb_ctrl;

    localparam int A = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [15:0]  req_addr = '0;
    logic         burst_en = 1'b0;
    logic [15:0]  code_addr;
    logic [3:0]   bank_sel;
    logic [3:0]   bank_oe;
    logic [127:0] bank_rdata;
    logic [31:0]  instr;
    logic         instr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ifb_ctrl #(.ACC_CYC(A), .MIN_BURST(4)) i_ifb_ctrl (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
        .burst_en (burst_en), .code_addr (code_addr), .bank_sel (bank_sel),
        .bank_oe (bank_oe), .bank_rdata (bank_rdata), .instr (instr),
        .instr_valid (instr_valid)
    );

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    // bank arrays with a fixed access time of A clocks
    logic [31:0] stg [4][A];
    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            stg[b][0] <= bank_sel[b] ? memf({code_addr[15:2], 2'(b)}) : 32'hBAD0_0000;
            for (int j = 1; j < A; j++) stg[b][j] <= stg[b][j-1];
        end
    end
    always_comb begin
        for (int b = 0; b < 4; b++)
            bank_rdata[b*32 +: 32] = bank_oe[b] ? stg[b][A-1] : (32'hFFFF_0000 | 32'(b));
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // full burst of len words from st; hold=0 keeps burst_en low throughout
    task automatic run(input logic [15:0] st, input int len, input bit hold, input string tag);
        for (int c = 0; c <= len + A + 4; c++) begin
            logic [15:0] a;
            logic [3:0]  es;
            logic [3:0]  eo;
            bit          ev;
            @(negedge clk);
            req_valid = (c == 0);
            req_addr  = st;
            burst_en  = hold && (c >= 1) && (c <= len);
            #1;
            a  = st + 16'(c - 1);
            es = (c >= 1 && c <= len) ? (4'b1 << a[1:0]) : 4'b0;
            chk(bank_sel == es, {tag, " R6 bank_sel"}, 32'(bank_sel), 32'(es));
            if (c >= 1 && c <= len)
                chk(code_addr == a, {tag, " R9 code_addr"}, 32'(code_addr), 32'(a));
            if (c >= 1) begin
                a  = st + 16'(c - 1 - A);
                eo = (c >= A + 1 && c <= A + len) ? (4'b1 << a[1:0]) : 4'b0;
                chk(bank_oe == eo, {tag, " R7 bank_oe"}, 32'(bank_oe), 32'(eo));
                ev = (c >= A + 2) && (c <= A + 1 + len);
                a  = st + 16'(c - A - 2);
                if (c == A + 2)
                    chk(instr_valid == 1'b1, {tag, " R2 first valid"}, 32'(instr_valid), 32'(1));
                else if (c == A + 2 + len)
                    chk(instr_valid == 1'b0, {tag, (len > 4) ? " R5 end" : " R4 end"}, 32'(instr_valid), 32'(0));
                else
                    chk(instr_valid == ev, {tag, ev ? " R3 valid run" : " R10 valid low"}, 32'(instr_valid), 32'(ev));
                if (ev && instr_valid)
                    chk(instr == memf(a), {tag, " R3 data"}, instr, memf(a));
            end
        end
    endtask

    // start a burst and leave it running for k cycles, unchecked
    task automatic pre(input logic [15:0] st, input int k);
        for (int c = 0; c < k; c++) begin
            @(negedge clk);
            req_valid = (c == 0);
            req_addr  = st;
            burst_en  = 1'b1;
        end
    endtask

    // stimulus table: {start address, word count}
    localparam logic [23:0] VEC [6] = '{
        {16'h0000, 8'd4},
        {16'h0001, 8'd5},
        {16'h0102, 8'd8},
        {16'h3FF3, 8'd6},
        {16'h7777, 8'd12},
        {16'hFFFE, 8'd6}   // R9 wrap through 0
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(instr_valid == 1'b0, "R1 reset valid", 32'(instr_valid), 0);
        chk(bank_sel == 4'b0, "R1 reset sel", 32'(bank_sel), 0);
        chk(bank_oe == 4'b0, "R1 reset oe", 32'(bank_oe), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(instr_valid == 1'b0, "R1 after reset valid", 32'(instr_valid), 0);

        for (int i = 0; i < 6; i++)
            run(VEC[i][23:8], int'(VEC[i][7:0]), 1'b1, "table");

        run(16'h0040, 4, 1'b0, "R4 min burst");

        // R5: raising burst_en after the burst ended issues nothing
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            burst_en = 1'b1;
            #1;
            chk(bank_sel == 4'b0, "R5 no reissue sel", 32'(bank_sel), 0);
            chk(instr_valid == 1'b0, "R5 no reissue valid", 32'(instr_valid), 0);
        end

        // R8: cancel mid-burst, and exactly at the first visible word
        pre(16'h1000, 7);
        run(16'h2003, 6, 1'b1, "R8 cancel mid");
        pre(16'h1100, A + 2);
        run(16'h2201, 5, 1'b1, "R8 cancel first");
        pre(16'h1200, 1);
        run(16'h2300, 4, 1'b1, "R8 cancel early");

        // R1: reset during a burst
        pre(16'h0200, 5);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(instr_valid == 1'b0, "R1 mid reset valid", 32'(instr_valid), 0);
        chk(bank_sel == 4'b0, "R1 mid reset sel", 32'(bank_sel), 0);
        chk(bank_oe == 4'b0, "R1 mid reset oe", 32'(bank_oe), 0);
        @(negedge clk);
        rst = 1'b0;
        run(16'h0303, 7, 1'b1, "R1 recovery");

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule